// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken, so the fetch stage can run ahead of branch resolution. A table of 2-bit saturating counters is indexed by a mix of recent branch outcomes and bits of the branch address. Because of this, the block learns repeating patterns as well as the bias of each address. The prediction side is purely combinational: a fetch PC goes in and a direction comes out in the same cycle. The block also returns the history value it used, and the pipeline carries that value along with the branch as a checkpoint.

When the branch resolves, the pipeline presents the branch PC, the actual outcome, the checkpointed history and a mispredict flag on the update side. The counter selected by the checkpoint moves one step toward the actual outcome. The history register then takes in the actual outcome. On a mispredict, the history is first rewound to the checkpoint. A `MODE` parameter chooses how the table index is built:

- 0: history XOR PC bits, one global history.
- 1: history concatenated above PC bits, one global history.
- 2: one history register per branch slot chosen by PC bits, with the PC bits placed above that history.

Top module: `dirpred2l`

## Requirements
- R1: After reset every counter holds weakly not taken (binary 01) and every history register is zero, so `pred_taken` is 0 and `pred_hist` is 0.
- R2: Counters use 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. An update with outcome taken adds one, saturating at 11. An update with outcome not taken subtracts one, saturating at 00.
- R3: `pred_taken` is 1 exactly when the selected counter is 10 or 11. An entry at 11 therefore needs two not-taken updates before its prediction becomes not taken.
- R4: In MODE 0 the table index is `hist XOR pc[HIST_W+1:2]`.
- R5: In MODE 1 the table index is `{hist, pc[SEL_PC_W+1:2]}`, with the history in the upper bits.
- R6: In MODE 2 each slot `pc[LOC_PC_W+1:2]` owns its own history register. The table index is `{pc[LOC_PC_W+1:2], hist}`, and `pred_hist` shows the history of the slot addressed by `pred_pc`.
- R7: On an update the history shifts left by one and the actual outcome enters bit 0 (1 means taken). Without a mispredict the current register is shifted. With `upd_mispred` set, `upd_hist` is shifted instead.
- R8: The counter changed by an update is the one indexed by `upd_pc` and `upd_hist`, not by the current history.
- R9: When a prediction reads the entry being updated in the same cycle, it returns the old counter value. The new value is visible from the next cycle.
- R10: With HIST_W = 2 in MODE 2, a branch taken every third time is learned. After training, it is predicted with no mispredicts.
- R11: A cycle without `upd_valid` changes no counter and no history, so the prediction for an unchanged `pred_pc` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | Predicted direction, same cycle |
| pred_hist | output | HIST_W | History used for this prediction (checkpoint) |
| upd_valid | input | 1 | Resolved branch present |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_mispred | input | 1 | Prediction was wrong; rewind history to `upd_hist` |
| upd_hist | input | HIST_W | History checkpoint captured at prediction time |

## Verification
The predicted direction and history are combinational, so the bench reads them 1 ns after driving `pred_pc` on the falling edge, before the next rising edge. An update takes effect at the next rising edge. The bench applies it to its reference model right after that edge, so the following falling-edge sample sees the new state. This is also how the same-cycle read of an entry under update is shown to return the old value. Three instances, one per index mode, run the same randomized traffic next to directed saturation, collision and period-three pattern sequences.

// File: rtl/dirpred2l.sv
module dirpred2l #(
  parameter int PC_W     = 16,
  parameter int HIST_W   = 4,
  parameter int MODE     = 0,
  parameter int SEL_PC_W = 2,
  parameter int LOC_PC_W = 2,
  parameter int PC_LSB   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic              upd_mispred,
  input  logic [HIST_W-1:0] upd_hist
);
  localparam int PCB_W   = (MODE == 0) ? HIST_W : (MODE == 1) ? SEL_PC_W : LOC_PC_W;
  localparam int IDX_W   = (MODE == 0) ? HIST_W : HIST_W + PCB_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [1:0] CTR_INIT = 2'b01;

  logic [PCB_W-1:0]  p_pcb, u_pcb;
  logic [IDX_W-1:0]  p_idx, u_idx;
  logic [HIST_W-1:0] cur_h, base_h, nxt_h;
  logic [1:0]        pht [ENTRIES];
  logic [1:0]        u_ctr, u_ctr_nxt;

  assign p_pcb = pred_pc[PC_LSB +: PCB_W];
  assign u_pcb = upd_pc[PC_LSB +: PCB_W];

  generate
    if (MODE == 0) begin : g_xor
      assign p_idx = pred_hist ^ p_pcb;
      assign u_idx = upd_hist ^ u_pcb;
    end else if (MODE == 1) begin : g_cat
      assign p_idx = {pred_hist, p_pcb};
      assign u_idx = {upd_hist, u_pcb};
    end else begin : g_slot
      assign p_idx = {p_pcb, pred_hist};
      assign u_idx = {u_pcb, upd_hist};
    end
  endgenerate

  assign base_h = upd_mispred ? upd_hist : cur_h;
  assign nxt_h  = {base_h[HIST_W-2:0], upd_taken};

  generate
    if (MODE == 2) begin : g_lht
      localparam int SLOTS = 1 << LOC_PC_W;
      logic [HIST_W-1:0] lht [SLOTS];
      assign pred_hist = lht[p_pcb];
      assign cur_h     = lht[u_pcb];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < SLOTS; i++) lht[i] <= '0;
        end else if (upd_valid) begin
          lht[u_pcb] <= nxt_h;
        end
      end
    end else begin : g_ghr
      logic [HIST_W-1:0] ghr;
      assign pred_hist = ghr;
      assign cur_h     = ghr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ghr <= '0;
        else if (upd_valid) ghr <= nxt_h;
      end
    end
  endgenerate

  assign u_ctr = pht[u_idx];

  always_comb begin
    if (upd_taken) u_ctr_nxt = (u_ctr == 2'b11) ? u_ctr : u_ctr + 2'd1;
    else           u_ctr_nxt = (u_ctr == 2'b00) ? u_ctr : u_ctr - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) pht[i] <= CTR_INIT;
    end else if (upd_valid) begin
      pht[u_idx] <= u_ctr_nxt;
    end
  end

  assign pred_taken = pht[p_idx][1];
endmodule

// File: rtl/dirpred2l_chk.sv
module dirpred2l_chk #(
  parameter int PC_W   = 16,
  parameter int HIST_W = 4,
  parameter int MODE   = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_taken,
  input logic [HIST_W-1:0] pred_hist,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic              upd_mispred,
  input logic [HIST_W-1:0] upd_hist
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pred_hist == '0 && !pred_taken)); // R1

  AST_IDLE_PRED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(pred_pc) -> $stable(pred_taken))); // R11

  generate
    if (MODE != 2) begin : g_glb
      AST_OUTCOME_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (pred_hist[0] == $past(upd_taken))); // R7

      AST_MISPRED_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_mispred) |=> (pred_hist[HIST_W-1:1] == $past(upd_hist[HIST_W-2:0]))); // R7

      AST_IDLE_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(pred_hist)); // R11
    end
  endgenerate
endmodule

bind dirpred2l dirpred2l_chk #(.PC_W(PC_W), .HIST_W(HIST_W), .MODE(MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
  .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .upd_mispred(upd_mispred), .upd_hist(upd_hist)
);

// File: tb/dirpred2l_tb.sv
`timescale 1ns/1ps
module dirpred2l_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] pred_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic [3:0] uh0 = '0, uh1 = '0;
  logic [1:0] uh2 = '0;
  logic mis0 = 1'b0, mis1 = 1'b0, mis2 = 1'b0;
  logic pt0, pt1, pt2;
  logic [3:0] ph0, ph1;
  logic [1:0] ph2;

  dirpred2l #(.MODE(0)) u_dut (.clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt0),
    .pred_hist(ph0), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_mispred(mis0), .upd_hist(uh0));
  dirpred2l #(.MODE(1)) u_dut_sel (.clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt1),
    .pred_hist(ph1), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_mispred(mis1), .upd_hist(uh1));
  dirpred2l #(.MODE(2), .HIST_W(2)) u_dut_loc (.clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
    .pred_taken(pt2), .pred_hist(ph2), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_mispred(mis2), .upd_hist(uh2));

  int n_chk = 0, n_fail = 0;
  int ctr_m [3][256];
  int gh_m [3];
  int lh_m [4];
  int hw [3] = '{4, 4, 2};

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pcb(int m, int pc);
    return (m == 0) ? ((pc >> 2) & 15) : ((pc >> 2) & 3);
  endfunction

  function automatic int hist_of(int m, int pc);
    return (m == 2) ? lh_m[pcb(2, pc)] : gh_m[m];
  endfunction

  function automatic int idx(int m, int pc, int h);
    if (m == 0) return h ^ pcb(0, pc);
    if (m == 1) return (h << 2) | pcb(1, pc);
    return (pcb(2, pc) << 2) | h;
  endfunction

  function automatic int get_uh(int m);
    return (m == 0) ? int'(uh0) : (m == 1) ? int'(uh1) : int'(uh2);
  endfunction
  function automatic int get_mis(int m);
    return (m == 0) ? int'(mis0) : (m == 1) ? int'(mis1) : int'(mis2);
  endfunction
  function automatic int get_pt(int m);
    return (m == 0) ? int'(pt0) : (m == 1) ? int'(pt1) : int'(pt2);
  endfunction
  function automatic int get_ph(int m);
    return (m == 0) ? int'(ph0) : (m == 1) ? int'(ph1) : int'(ph2);
  endfunction

  task automatic model_reset();
    for (int m = 0; m < 3; m++) begin
      for (int i = 0; i < 256; i++) ctr_m[m][i] = 1;
      gh_m[m] = 0;
    end
    for (int s = 0; s < 4; s++) lh_m[s] = 0;
  endtask

  task automatic model_update(int m);
    int uh, i, base, nh;
    uh = get_uh(m);
    i = idx(m, upd_pc, uh);
    if (upd_taken) ctr_m[m][i] = (ctr_m[m][i] == 3) ? 3 : ctr_m[m][i] + 1;
    else           ctr_m[m][i] = (ctr_m[m][i] == 0) ? 0 : ctr_m[m][i] - 1;
    base = get_mis(m) ? uh : hist_of(m, upd_pc);
    nh = ((base << 1) | int'(upd_taken)) & ((1 << hw[m]) - 1);
    if (m == 2) lh_m[pcb(2, upd_pc)] = nh;
    else        gh_m[m] = nh;
  endtask

  task automatic step(bit train);
    string t;
    #1;
    if (train) begin
      uh0 = ph0; uh1 = ph1; uh2 = ph2;
      mis0 = (pt0 != upd_taken); mis1 = (pt1 != upd_taken); mis2 = (pt2 != upd_taken);
    end
    for (int m = 0; m < 3; m++) begin
      t = (m == 0) ? "R4 R8" : (m == 1) ? "R5 R8" : "R6 R8";
      if (!upd_valid) t = {t, " R11"};
      chk(t, get_pt(m), (ctr_m[m][idx(m, pred_pc, hist_of(m, pred_pc))] >= 2) ? 1 : 0);
      chk("R7", get_ph(m), hist_of(m, pred_pc));
    end
    @(posedge clk);
    if (upd_valid) for (int m = 0; m < 3; m++) model_update(m);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; upd_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    #1;
    chk("R1", pt0, 0); chk("R1", pt1, 0); chk("R1", pt2, 0);
    chk("R1", ph0, 0); chk("R1", ph1, 0); chk("R1", ph2, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic upd_entry0(bit tk);
    upd_valid = 1'b1; upd_pc = '0; upd_taken = tk;
    uh0 = '0; uh1 = '0; uh2 = '0; mis0 = 1'b1; mis1 = 1'b1; mis2 = 1'b1;
    pred_pc = 16'(gh_m[0] << 2);
    step(0);
  endtask

  task automatic idle_entry0();
    upd_valid = 1'b0;
    pred_pc = 16'(gh_m[0] << 2);
  endtask

  task automatic run_all();
    int bad;
    do_reset();
    // R2 / R3 directed on gshare entry 0
    repeat (3) upd_entry0(1'b1);
    idle_entry0(); #1; chk("R2", pt0, 1); step(0);
    upd_entry0(1'b0);
    idle_entry0(); #1; chk("R3", pt0, 1); step(0);
    upd_entry0(1'b0);
    idle_entry0(); #1; chk("R3", pt0, 0); step(0);
    // R9: read entry 0 while updating it
    upd_valid = 1'b1; upd_pc = '0; upd_taken = 1'b1; uh0 = '0; mis0 = 1'b1;
    pred_pc = 16'(gh_m[0] << 2);
    #1; chk("R9", pt0, 0);
    step(0);
    idle_entry0(); #1; chk("R9", pt0, 1); step(0);

    // R10: period-three pattern learned with 2-bit local history
    do_reset();
    bad = 0;
    for (int k = 0; k < 60; k++) begin
      pred_pc = 16'h0040; upd_pc = 16'h0040; upd_valid = 1'b1;
      upd_taken = (k % 3 == 2);
      step(1);
      if (k >= 42 && mis2) bad++;
    end
    chk("R10", bad, 0);

    // random traffic on all three modes
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      pred_pc   = 16'($urandom);
      upd_valid = ($urandom % 10) < 7;
      upd_pc    = ($urandom % 2) ? pred_pc : 16'($urandom);
      upd_taken = $urandom % 2;
      uh0 = 4'($urandom); uh1 = 4'($urandom); uh2 = 2'($urandom);
      mis0 = ($urandom % 10) < 3; mis1 = ($urandom % 10) < 3; mis2 = ($urandom % 10) < 3;
      step(0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule